// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a two-part logical address, a segment number plus an offset, into a physical address. The lookup uses a segment table held in memory. A base register gives the table's location. A length register gives the number of segments in use. A request with a segment number at or above the length is rejected at once and never reaches memory. Any other request makes two reads, one after the other, of the 8-byte table entry. The first read returns the segment's physical base. The second returns its limit and a valid bit. The block then answers with either the physical address or a 2-bit fault code.

Software loads the two registers through their write strobes, then issues one translation at a time on the request port. The memory read port carries a one-cycle read strobe with an address. Read data may come back after any number of cycles and is marked by a one-cycle data-valid strobe. Only one read is outstanding at any time.

Top module: `seg_xlate`

## Requirements
- R1: After reset, rsp_valid and mem_rd_en are 0, req_ready is 1, and both the table base and the table length are 0, so every segment number is out of range.
- R2: A request accepted with req_seg >= length returns rsp_fault = 2'b01 and rsp_paddr = 0, with rsp_valid high in the cycle after acceptance, and issues no memory read.
- R3: A request accepted with req_seg < length makes exactly two reads, one strobe at a time. The first read is at base + 8*req_seg. The second is at base + 8*req_seg + 4 and is strobed in the cycle after the first read's data arrives.
- R4: If bit 31 of the second word (the valid bit) is 0, the response is rsp_fault = 2'b10 and rsp_paddr = 0, whatever the limit holds.
- R5: If the entry is valid and req_off >= limit, the response is rsp_fault = 2'b11 and rsp_paddr = 0. The limit is bits [16:0] of the second word, so a limit of 65536 admits every offset.
- R6: If the entry is valid and req_off < limit, the response is rsp_fault = 2'b00 and rsp_paddr = first word + req_off, modulo 2^32.
- R7: While a table read is in flight, req_ready is 0 and rsp_valid is 0. The response appears in the cycle after the second word's data-valid strobe.
- R8: A base or length write in the same cycle that a request is accepted does not affect that request; the new value applies to requests accepted later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_we | input | 1 | Write strobe for the table base register |
| base_wdata | input | 32 | New table base |
| len_we | input | 1 | Write strobe for the table length register |
| len_wdata | input | 9 | New segment count (0 to 256) |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_seg | input | 8 | Segment number |
| req_off | input | 16 | Offset within the segment |
| rsp_valid | output | 1 | Response valid, one cycle |
| rsp_fault | output | 2 | 00 ok, 01 segment out of range, 10 invalid, 11 offset out of bounds |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 32 | Memory read byte address |
| mem_rd_valid | input | 1 | Read data valid strobe |
| mem_rd_data | input | 32 | Read data |

## Verification
A register write can land in the same cycle as the acceptance of a translation request. The bench provokes this with a length write that would flip the request's range verdict, and separately with a base write to an unrelated address. It judges the response and the captured read addresses against a model that uses the values held before the write. A follow-up request then confirms that the new value has taken effect. Memory latency is randomised between one and three cycles so that the two entry reads fall at varying distances from the response.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int SEG_W = 8,
  parameter int OFF_W = 16,
  parameter int AW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_we,
  input  logic [AW-1:0]    base_wdata,
  input  logic             len_we,
  input  logic [SEG_W:0]   len_wdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SEG_W-1:0] req_seg,
  input  logic [OFF_W-1:0] req_off,
  output logic             rsp_valid,
  output logic [1:0]       rsp_fault,
  output logic [AW-1:0]    rsp_paddr,
  output logic             mem_rd_en,
  output logic [AW-1:0]    mem_rd_addr,
  input  logic             mem_rd_valid,
  input  logic [AW-1:0]    mem_rd_data
);
  localparam int VBIT = AW - 1;
  localparam logic [1:0] F_OK = 2'd0, F_SEG = 2'd1, F_INV = 2'd2, F_BND = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_W0, S_W1} st_t;

  st_t              st;
  logic [AW-1:0]    tbl_base;
  logic [SEG_W:0]   tbl_len;
  logic [AW-1:0]    seg_base;
  logic [OFF_W-1:0] off_q;

  wire              accept  = req_valid && req_ready;
  wire              seg_bad = {1'b0, req_seg} >= tbl_len;
  wire [OFF_W:0]    lim     = mem_rd_data[OFF_W:0];
  wire              ent_ok  = mem_rd_data[VBIT];

  assign req_ready = (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      tbl_base    <= '0;
      tbl_len     <= '0;
      seg_base    <= '0;
      off_q       <= '0;
      rsp_valid   <= 1'b0;
      rsp_fault   <= F_OK;
      rsp_paddr   <= '0;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
    end else begin
      rsp_valid <= 1'b0;
      mem_rd_en <= 1'b0;
      if (base_we) tbl_base <= base_wdata;
      if (len_we)  tbl_len  <= len_wdata;
      case (st)
        S_IDLE: if (accept) begin
          off_q <= req_off;
          if (seg_bad) begin
            rsp_valid <= 1'b1;
            rsp_fault <= F_SEG;
            rsp_paddr <= '0;
          end else begin
            mem_rd_en   <= 1'b1;
            mem_rd_addr <= tbl_base + AW'({req_seg, 3'b000});
            st          <= S_W0;
          end
        end
        S_W0: if (mem_rd_valid) begin
          seg_base    <= mem_rd_data;
          mem_rd_en   <= 1'b1;
          mem_rd_addr <= mem_rd_addr + AW'(4);
          st          <= S_W1;
        end
        S_W1: if (mem_rd_valid) begin
          rsp_valid <= 1'b1;
          st        <= S_IDLE;
          if (!ent_ok) begin
            rsp_fault <= F_INV;
            rsp_paddr <= '0;
          end else if ({1'b0, off_q} >= lim) begin
            rsp_fault <= F_BND;
            rsp_paddr <= '0;
          end else begin
            rsp_fault <= F_OK;
            rsp_paddr <= seg_base + AW'(off_q);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r2_seg_fault: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && ({1'b0, req_seg} >= tbl_len) |=> rsp_valid && rsp_fault == F_SEG);
  a_r2_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && ({1'b0, req_seg} >= tbl_len) |=> !mem_rd_en);
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);
  a_r7_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !req_ready && !rsp_valid);
endmodule

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;
  localparam logic [31:0] TBL = 32'h0001_0000;

  logic        clk = 0, rst_n = 0;
  logic        base_we = 0, len_we = 0, req_valid = 0;
  logic [31:0] base_wdata = 0;
  logic [8:0]  len_wdata = 0;
  logic [7:0]  req_seg = 0;
  logic [15:0] req_off = 0;
  logic        req_ready, rsp_valid, mem_rd_en;
  logic [1:0]  rsp_fault;
  logic [31:0] rsp_paddr, mem_rd_addr;
  logic        mem_rd_valid = 0;
  logic [31:0] mem_rd_data = 0;

  always #10 clk = ~clk;

  seg_xlate u_dut (.clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
    .len_we(len_we), .len_wdata(len_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_seg(req_seg), .req_off(req_off), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_paddr(rsp_paddr), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data));

  logic [31:0] w0 [256];
  logic [31:0] w1 [256];
  logic [31:0] m_base = 0;
  logic [8:0]  m_len  = 0;
  int tests = 0, fails = 0;

  int          reads = 0;
  logic [31:0] raddr [4];
  int          pend = 0;
  logic [31:0] paddr_q = 0;

  function automatic logic [31:0] memword(input logic [31:0] a);
    logic [31:0] o;
    o = a - TBL;
    return o[2] ? w1[o[10:3]] : w0[o[10:3]];
  endfunction

  always @(posedge clk) begin
    mem_rd_valid <= 1'b0;
    if (pend > 0) begin
      pend <= pend - 1;
      if (pend == 1) begin
        mem_rd_valid <= 1'b1;
        mem_rd_data  <= memword(paddr_q);
      end
    end
    if (mem_rd_en) begin
      paddr_q <= mem_rd_addr;
      pend    <= 1 + int'($urandom % 3);
      if (reads < 4) raddr[reads] <= mem_rd_addr;
      reads   <= reads + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_fault(input logic [7:0] s, input logic [15:0] o, input logic [8:0] ln);
    if ({1'b0, s} >= ln) return 2'd1;
    if (!w1[s][31]) return 2'd2;
    if ({1'b0, o} >= w1[s][16:0]) return 2'd3;
    return 2'd0;
  endfunction

  task automatic xlate(input logic [7:0] s, input logic [15:0] o, input string tag,
                       input bit wl = 0, input logic [8:0] nl = 0,
                       input bit wb = 0, input logic [31:0] nb = 0);
    logic [1:0]  ef;
    logic [31:0] ep, eb;
    int n;
    ef = exp_fault(s, o, m_len);
    ep = (ef == 2'd0) ? w0[s] + {16'd0, o} : 32'd0;
    eb = m_base + {21'd0, s, 3'b000};
    @(negedge clk);
    reads = 0;
    req_valid = 1; req_seg = s; req_off = o;
    len_we = wl; len_wdata = nl; base_we = wb; base_wdata = nb;
    @(negedge clk);
    req_valid = 0; len_we = 0; base_we = 0;
    if (wl) m_len = nl;
    if (wb) m_base = nb;
    if (ef != 2'd1) check(!req_ready, {tag, " R7 ready low"}, 32'(req_ready), 0);
    n = 0;
    while (!rsp_valid && n < 40) begin
      @(negedge clk);
      n++;
    end
    check(rsp_valid, {tag, " R7 response"}, 32'(rsp_valid), 1);
    check(rsp_fault == ef, {tag, " R2/R4/R5/R6 fault"}, 32'(rsp_fault), 32'(ef));
    check(rsp_paddr == ep, {tag, " R6 paddr"}, rsp_paddr, ep);
    check(reads == ((ef == 2'd1) ? 0 : 2), {tag, " R2/R3 read count"}, reads, (ef == 2'd1) ? 0 : 2);
    if (ef != 2'd1) begin
      check(raddr[0] == eb, {tag, " R3 first addr"}, raddr[0], eb);
      check(raddr[1] == eb + 4, {tag, " R3 second addr"}, raddr[1], eb + 4);
    end
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) begin
      w0[i] = $urandom;
      w1[i] = {($urandom % 4) != 0, 14'd0, 17'($urandom % 65537)};
    end
    w1[3] = {1'b1, 14'd0, 17'd100};
    w1[4] = {1'b0, 14'd0, 17'd0};
    w1[5] = {1'b1, 14'd0, 17'd65536};
    w0[5] = 32'hFFFF_FFF0;
    repeat (3) @(negedge clk);
    check(!rsp_valid && !mem_rd_en && req_ready, "R1 reset outputs", {rsp_valid, mem_rd_en, req_ready}, 3'b001);
    rst_n = 1;
    xlate(8'd0, 16'd1, "R1 len zero");
    @(negedge clk);
    base_we = 1; base_wdata = TBL; len_we = 1; len_wdata = 9'd16;
    @(negedge clk);
    base_we = 0; len_we = 0; m_base = TBL; m_len = 9'd16;
    xlate(8'd16, 16'd0, "R2 seg==len");
    xlate(8'd200, 16'd5, "R2 seg>len");
    xlate(8'd3, 16'd99, "R6 off=lim-1");
    xlate(8'd3, 16'd100, "R5 off=lim");
    xlate(8'd4, 16'd0, "R4 invalid");
    xlate(8'd5, 16'hFFFF, "R6 wrap full limit");
    xlate(8'd20, 16'd7, "R8 old len", 1, 9'd256);
    xlate(8'd20, 16'd7, "R8 new len");
    xlate(8'd6, 16'd3, "R8 old base", 0, 0, 1, 32'h0BAD_0000);
    @(negedge clk);
    base_we = 1; base_wdata = TBL;
    @(negedge clk);
    base_we = 0; m_base = TBL;
    for (int k = 0; k < 60; k++)
      xlate(8'($urandom % 256), 16'($urandom), "R3 random", (k % 17) == 5, 9'($urandom % 257));
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule